// File: doc/BRIEF.md
# Dual-Region SRAM Port Arbiter

This block shares the single access port of each of two SRAM regions (a lower and an upper half of one memory) between two requesters: the processor and a backdoor master. Each region has its own arbiter. Grants are combinational and last one cycle. A grant is decided from the requests of the current cycle and from the history registers, which are updated on the clock edge.

Software picks one of four policies for each region through a 2-bit field of a shared 32-bit control register. The four policies are plain round robin, round robin biased toward the backdoor, fixed priority with the processor first, and fixed priority with the backdoor first. A write-protect bit for each region stops granted writes from reaching the memory. The requester whose write was blocked receives a one-cycle error pulse.

The SRAM array and any bus protocol conversion sit outside this block. Region index 0 is the lower region and index 1 is the upper region on every per-region vector port.

Top module: `sram_dual_arbiter`

## Requirements
- R1: After reset the control register reads 0, so both regions are in mode 00 with write protect off. No grant is given while no request is present.
- R2: Control register layout: bits 25:24 hold the upper-region mode and bit 26 holds its write protect. Bits 29:28 hold the lower-region mode and bit 30 holds its write protect. All other bits read 0. A write is visible on cfg_rdata in the cycle after the write cycle.
- R3: A lone requester in a region is granted in the same cycle, whatever the mode.
- R4: A region never grants both requesters in one cycle, and a grant appears only together with its own request.
- R5: Mode 00 (plain round robin): in a contested cycle, the requester that was not granted most recently wins. Every grant, contested or not, updates this history. After reset the history treats the backdoor as the most recent winner, so the processor wins the first contested cycle.
- R6: Mode 01 (biased round robin): the backdoor wins contested cycles. After the backdoor has won two contested cycles in a row, the processor wins the next contested cycle, and the run count restarts. Uncontested cycles leave the run count unchanged.
- R7: Mode 10: the processor wins every contested cycle.
- R8: Mode 11: the backdoor wins every contested cycle.
- R9: While write protect of a region is set, a granted write drives mem_en=0 and mem_we=0, and sets the granted requester's error output for that cycle. While write protect is clear, a granted write drives mem_en=1 and mem_we=1 with no error.
- R10: Granted reads are unaffected by write protect: mem_en=1, mem_we=0, no error.
- R11: A mode write applies from the cycle after the write cycle. The cycle of the write still uses the old mode. A mode change leaves the round-robin history intact.
- R12: The two regions arbitrate independently, each with its own mode, write protect and history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| cpu_req | input | 2 | Processor request, one bit per region |
| cpu_wr | input | 2 | Processor write flag, one bit per region |
| bd_req | input | 2 | Backdoor request, one bit per region |
| bd_wr | input | 2 | Backdoor write flag, one bit per region |
| cpu_gnt | output | 2 | Processor grant, one bit per region |
| bd_gnt | output | 2 | Backdoor grant, one bit per region |
| mem_en | output | 2 | Access forwarded to the region's memory |
| mem_we | output | 2 | Forwarded access is a write |
| cpu_err | output | 2 | Processor write blocked by write protect |
| bd_err | output | 2 | Backdoor write blocked by write protect |

## Verification
Lone requests are tried in every mode to confirm that no policy starves an uncontested requester. Runs of contested cycles mixed with lone grants are tried next. These separate the four policies: round robin alternates and counts lone grants as history, the biased mode yields once after two backdoor wins, and the fixed modes never change the winner. A mode write made during a contested cycle shows that the old mode still decides that cycle and that the history survives the change. Protected and unprotected reads and writes from both requesters, in both regions at once, show that the write gate acts only on writes and only in its own region.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

   typedef enum logic [1:0] {
      ARB_RR      = 2'b00,
      ARB_RR_BD   = 2'b01,
      ARB_FIX_CPU = 2'b10,
      ARB_FIX_BD  = 2'b11
   } arb_mode_e;

   localparam int ARB_MODE_W = 2;

endpackage

// File: rtl/sram_arb_ctrl.sv
module sram_arb_ctrl
   import sram_arb_pkg::*;
#(
   parameter int CTRL_W      = 32,
   parameter int LO_MODE_LSB = 28,
   parameter int LO_WP_BIT   = 30,
   parameter int UP_MODE_LSB = 24,
   parameter int UP_WP_BIT   = 26
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [CTRL_W-1:0]       wr_data,
   output logic [CTRL_W-1:0]       rd_data,
   output logic [2*ARB_MODE_W-1:0] mode_flat,
   output logic [1:0]              wp_vec
);

   localparam logic [CTRL_W-1:0] FIELD_MASK =
      ({{(CTRL_W-ARB_MODE_W){1'b0}}, {ARB_MODE_W{1'b1}}} << LO_MODE_LSB) |
      ({{(CTRL_W-ARB_MODE_W){1'b0}}, {ARB_MODE_W{1'b1}}} << UP_MODE_LSB) |
      ({{(CTRL_W-1){1'b0}}, 1'b1} << LO_WP_BIT) |
      ({{(CTRL_W-1){1'b0}}, 1'b1} << UP_WP_BIT);

   if (LO_MODE_LSB + ARB_MODE_W > CTRL_W || UP_MODE_LSB + ARB_MODE_W > CTRL_W) begin : g_bad_mode_pos
      $error("sram_arb_ctrl: mode field outside register");
   end
   if (LO_WP_BIT >= CTRL_W || UP_WP_BIT >= CTRL_W) begin : g_bad_wp_pos
      $error("sram_arb_ctrl: write-protect bit outside register");
   end

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= wr_data & FIELD_MASK;
      end
   end

   assign rd_data = ctrl_q;
   assign mode_flat[0*ARB_MODE_W +: ARB_MODE_W] = ctrl_q[LO_MODE_LSB +: ARB_MODE_W];
   assign mode_flat[1*ARB_MODE_W +: ARB_MODE_W] = ctrl_q[UP_MODE_LSB +: ARB_MODE_W];
   assign wp_vec[0] = ctrl_q[LO_WP_BIT];
   assign wp_vec[1] = ctrl_q[UP_WP_BIT];

endmodule

// File: rtl/sram_arb_core.sv
module sram_arb_core
   import sram_arb_pkg::*;
#(
   parameter int BIAS_RUN = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ARB_MODE_W-1:0] mode,
   input  logic                  cpu_req,
   input  logic                  bd_req,
   output logic                  cpu_gnt,
   output logic                  bd_gnt
);

   localparam int RUN_W = $clog2(BIAS_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BIAS_RUN);

   if (BIAS_RUN < 1) begin : g_bad_run
      $error("sram_arb_core: BIAS_RUN must be at least 1");
   end

   arb_mode_e        mode_e;
   logic             contest;
   logic             bd_wins;
   logic             last_bd_q;
   logic [RUN_W-1:0] run_q;

   assign mode_e  = arb_mode_e'(mode);
   assign contest = cpu_req & bd_req;

   always_comb begin
      unique case (mode_e)
         ARB_RR:      bd_wins = ~last_bd_q;
         ARB_RR_BD:   bd_wins = (run_q < RUN_MAX);
         ARB_FIX_CPU: bd_wins = 1'b0;
         ARB_FIX_BD:  bd_wins = 1'b1;
         default:     bd_wins = 1'b0;
      endcase
   end

   assign cpu_gnt = cpu_req & (~bd_req | ~bd_wins);
   assign bd_gnt  = bd_req  & (~cpu_req | bd_wins);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_bd_q <= 1'b1;
      end else if (cpu_gnt) begin
         last_bd_q <= 1'b0;
      end else if (bd_gnt) begin
         last_bd_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (contest && mode_e == ARB_RR_BD) begin
         run_q <= bd_gnt ? run_q + 1'b1 : '0;
      end
   end

endmodule

// File: rtl/sram_arb_wgate.sv
module sram_arb_wgate (
   input  logic cpu_gnt,
   input  logic bd_gnt,
   input  logic cpu_wr,
   input  logic bd_wr,
   input  logic wp,
   output logic mem_en,
   output logic mem_we,
   output logic cpu_err,
   output logic bd_err
);

   logic any_gnt;
   logic sel_wr;
   logic blocked;

   assign any_gnt = cpu_gnt | bd_gnt;
   assign sel_wr  = cpu_gnt ? cpu_wr : bd_wr;
   assign blocked = any_gnt & sel_wr & wp;

   assign mem_en  = any_gnt & ~blocked;
   assign mem_we  = any_gnt & sel_wr & ~wp;
   assign cpu_err = cpu_gnt & cpu_wr & wp;
   assign bd_err  = bd_gnt & bd_wr & wp;

endmodule

// File: rtl/sram_dual_arbiter.sv
module sram_dual_arbiter
   import sram_arb_pkg::*;
#(
   parameter int CTRL_W      = 32,
   parameter int LO_MODE_LSB = 28,
   parameter int LO_WP_BIT   = 30,
   parameter int UP_MODE_LSB = 24,
   parameter int UP_WP_BIT   = 26,
   parameter int BIAS_RUN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] cfg_rdata,
   input  logic [1:0]        cpu_req,
   input  logic [1:0]        cpu_wr,
   input  logic [1:0]        bd_req,
   input  logic [1:0]        bd_wr,
   output logic [1:0]        cpu_gnt,
   output logic [1:0]        bd_gnt,
   output logic [1:0]        mem_en,
   output logic [1:0]        mem_we,
   output logic [1:0]        cpu_err,
   output logic [1:0]        bd_err
);

   localparam int REGIONS = 2;

   logic [REGIONS*ARB_MODE_W-1:0] mode_flat;
   logic [REGIONS-1:0]            wp_vec;

   sram_arb_ctrl #(
      .CTRL_W      (CTRL_W),
      .LO_MODE_LSB (LO_MODE_LSB),
      .LO_WP_BIT   (LO_WP_BIT),
      .UP_MODE_LSB (UP_MODE_LSB),
      .UP_WP_BIT   (UP_WP_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_data   (cfg_wdata),
      .rd_data   (cfg_rdata),
      .mode_flat (mode_flat),
      .wp_vec    (wp_vec)
   );

   for (genvar g = 0; g < REGIONS; g++) begin : g_region
      sram_arb_core #(
         .BIAS_RUN (BIAS_RUN)
      ) u_core (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (mode_flat[g*ARB_MODE_W +: ARB_MODE_W]),
         .cpu_req (cpu_req[g]),
         .bd_req  (bd_req[g]),
         .cpu_gnt (cpu_gnt[g]),
         .bd_gnt  (bd_gnt[g])
      );

      sram_arb_wgate u_wgate (
         .cpu_gnt (cpu_gnt[g]),
         .bd_gnt  (bd_gnt[g]),
         .cpu_wr  (cpu_wr[g]),
         .bd_wr   (bd_wr[g]),
         .wp      (wp_vec[g]),
         .mem_en  (mem_en[g]),
         .mem_we  (mem_we[g]),
         .cpu_err (cpu_err[g]),
         .bd_err  (bd_err[g])
      );
   end

endmodule

// File: rtl/sram_dual_arbiter_chk.sv
module sram_dual_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] mode_flat,
   input logic [1:0] wp_vec,
   input logic [1:0] cpu_req,
   input logic [1:0] cpu_wr,
   input logic [1:0] bd_req,
   input logic [1:0] bd_wr,
   input logic [1:0] cpu_gnt,
   input logic [1:0] bd_gnt,
   input logic [1:0] mem_en,
   input logic [1:0] mem_we,
   input logic [1:0] cpu_err,
   input logic [1:0] bd_err
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   for (genvar g = 0; g < 2; g++) begin : g_chk
      logic       contest;
      logic [1:0] md;
      assign contest = cpu_req[g] & bd_req[g];
      assign md      = mode_flat[2*g +: 2];

      // R4
      one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({cpu_gnt[g], bd_gnt[g]}));
      // R4
      gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_gnt[g] |-> cpu_req[g]) and (bd_gnt[g] |-> bd_req[g]));
      // R3
      lone_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_req[g] && !bd_req[g]) |-> cpu_gnt[g]);
      // R3
      lone_bd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bd_req[g] && !cpu_req[g]) |-> bd_gnt[g]);
      // R7
      fix_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (contest && md == 2'b10) |-> cpu_gnt[g]);
      // R8
      fix_bd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (contest && md == 2'b11) |-> bd_gnt[g]);
      // R5
      rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && contest && md == 2'b00 && $past(contest) && $past(md) == 2'b00)
            |-> (cpu_gnt[g] != $past(cpu_gnt[g])));
      // R9
      err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_err[g] || bd_err[g]) |-> (wp_vec[g] && !mem_en[g] && !mem_we[g]));
      // R9
      wp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wp_vec[g] |-> !mem_we[g]);
      // R10
      read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((cpu_gnt[g] && !cpu_wr[g]) || (bd_gnt[g] && !bd_wr[g]))
            |-> (mem_en[g] && !mem_we[g] && !cpu_err[g] && !bd_err[g]));
   end

endmodule

bind sram_dual_arbiter sram_dual_arbiter_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_flat (mode_flat),
   .wp_vec    (wp_vec),
   .cpu_req   (cpu_req),
   .cpu_wr    (cpu_wr),
   .bd_req    (bd_req),
   .bd_wr     (bd_wr),
   .cpu_gnt   (cpu_gnt),
   .bd_gnt    (bd_gnt),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .cpu_err   (cpu_err),
   .bd_err    (bd_err)
);

// File: tb/sram_dual_arbiter_tb.sv
module sram_dual_arbiter_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  cpu_req = '0, cpu_wr = '0, bd_req = '0, bd_wr = '0;
   logic [1:0]  cpu_gnt, bd_gnt, mem_en, mem_we, cpu_err, bd_err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_dual_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .bd_req(bd_req), .bd_wr(bd_wr), .cpu_gnt(cpu_gnt), .bd_gnt(bd_gnt),
      .mem_en(mem_en), .mem_we(mem_we), .cpu_err(cpu_err), .bd_err(bd_err)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      check(act === exp, req, act, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      cpu_req = '0; cpu_wr = '0; bd_req = '0; bd_wr = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = d;
      cpu_req = '0; bd_req = '0;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive one cycle of requests, then sample shortly after
   task automatic step(input logic [1:0] cr, input logic [1:0] cw, input logic [1:0] br, input logic [1:0] bw);
      @(negedge clk);
      cpu_req = cr; cpu_wr = cw; bd_req = br; bd_wr = bw;
      #1;
   endtask

   // region 0 grant pair {cpu,bd}
   function automatic logic [1:0] g0();
      return {cpu_gnt[0], bd_gnt[0]};
   endfunction

   task automatic t_reset();
      do_reset();
      step(2'b00, 2'b00, 2'b00, 2'b00);
      check_eq("R1 cfg_rdata after reset", cfg_rdata, 32'h0);
      check_eq("R1 no grants when idle", {cpu_gnt, bd_gnt, mem_en}, 6'h0);
   endtask

   task automatic t_layout();
      do_reset();
      cfg_write(32'hFFFF_FFFF);
      check_eq("R2 only defined fields stored", cfg_rdata, 32'h7700_0000);
      cfg_write(32'h4000_0000);
      check_eq("R2 lower wp at bit 30", cfg_rdata, 32'h4000_0000);
      step(2'b11, 2'b11, 2'b00, 2'b00);
      check_eq("R2 bit30 protects lower region only (mem_we)", mem_we, 2'b10);
      check_eq("R2 bit30 error only in lower region", cpu_err, 2'b01);
   endtask

   task automatic t_lone();
      do_reset();
      for (int m = 0; m < 4; m++) begin
         cfg_write((32'(m) << 28) | (32'(m) << 24));
         step(2'b11, 2'b00, 2'b00, 2'b00);
         check_eq($sformatf("R3 lone cpu granted mode %0d", m), cpu_gnt, 2'b11);
         step(2'b00, 2'b00, 2'b11, 2'b00);
         check_eq($sformatf("R3 lone bd granted mode %0d", m), bd_gnt, 2'b11);
         check_eq($sformatf("R4 no cpu grant without request mode %0d", m), cpu_gnt, 2'b00);
      end
   endtask

   task automatic t_rr();
      do_reset();
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R5 first contest after reset -> cpu", g0(), 2'b10);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R5 second contest -> bd", g0(), 2'b01);
      step(2'b01, 2'b00, 2'b00, 2'b00);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R5 lone cpu grant counts, contest -> bd", g0(), 2'b01);
      step(2'b00, 2'b00, 2'b01, 2'b00);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R5 lone bd grant counts, contest -> cpu", g0(), 2'b10);
   endtask

   task automatic t_bias();
      do_reset();
      cfg_write(32'h1000_0000);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R6 first contest -> bd", g0(), 2'b01);
      step(2'b01, 2'b00, 2'b00, 2'b00);
      check_eq("R6 lone cpu granted", g0(), 2'b10);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R6 uncontested cycle kept run, contest -> bd", g0(), 2'b01);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R6 after two bd wins -> cpu", g0(), 2'b10);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R6 run restarted -> bd", g0(), 2'b01);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R6 second of new run -> bd", g0(), 2'b01);
   endtask

   task automatic t_fixed();
      do_reset();
      cfg_write(32'h2300_0000);  // lower mode 10, upper mode 11
      for (int k = 0; k < 3; k++) begin
         step(2'b11, 2'b00, 2'b11, 2'b00);
         check_eq($sformatf("R7 lower mode 10 contest %0d -> cpu", k), {cpu_gnt[0], bd_gnt[0]}, 2'b10);
         check_eq($sformatf("R8 upper mode 11 contest %0d -> bd", k), {cpu_gnt[1], bd_gnt[1]}, 2'b01);
      end
      check_eq("R12 regions decide independently", {cpu_gnt, bd_gnt}, 4'b0110);
   endtask

   task automatic t_wp();
      do_reset();
      cfg_write(32'h0400_0000);  // upper wp
      step(2'b11, 2'b11, 2'b00, 2'b00);
      check_eq("R9 protected write blocked (mem_en)", mem_en, 2'b01);
      check_eq("R9 protected write blocked (mem_we)", mem_we, 2'b01);
      check_eq("R9 cpu error pulse upper only", cpu_err, 2'b10);
      step(2'b11, 2'b00, 2'b00, 2'b00);
      check_eq("R10 protected read forwarded (mem_en)", mem_en, 2'b11);
      check_eq("R10 read no write, no error", {mem_we, cpu_err, bd_err}, 6'h0);
      step(2'b00, 2'b00, 2'b11, 2'b11);
      check_eq("R9 bd error pulse upper only", bd_err, 2'b10);
      check_eq("R9 bd write forwarded in lower", {mem_en, mem_we}, 4'b0101);
      step(2'b00, 2'b00, 2'b00, 2'b00);
      check_eq("R9 error pulse ends", {cpu_err, bd_err}, 4'h0);
   endtask

   task automatic t_switch();
      do_reset();
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R11 mode 00 contest -> cpu", g0(), 2'b10);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 32'h2000_0000;
      cpu_req = 2'b01; bd_req = 2'b01;
      #1;
      check_eq("R11 write cycle still uses old mode -> bd", g0(), 2'b01);
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      check_eq("R11 new mode 10 next cycle -> cpu", g0(), 2'b10);
      cfg_write(32'h0000_0000);
      step(2'b01, 2'b00, 2'b01, 2'b00);
      check_eq("R11 history kept across mode change -> bd", g0(), 2'b01);
   endtask

   initial begin
      t_reset();
      t_layout();
      t_lone();
      t_rr();
      t_bias();
      t_fixed();
      t_wp();
      t_switch();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule